// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a parameterised set of interrupt request lines, up to 64, and turns each one into a request on one of up to 256 parent interrupt outputs. Software picks which output through an 8-bit vector entry for each line. Each line can be set for edge or level detection. The block keeps a pending bit and an in-service bit for each line and gates delivery through a per-line mask. A 32-bit register bus reaches the control registers as pairs of 32-bit halves. It also reaches two byte-wide tables, one of vectors and one of route entries.

Delivery goes through a small event engine with two states. A line that changes level creates a per-line event. So does a change in its mask bit, or a clear aimed at it. A newer event for the same line replaces an older one. In `ST_IDLE` the engine waits for any queued event and then moves to `ST_SERVE`. In `ST_SERVE` it retires the lowest-numbered queued event on each clock. It returns to `ST_IDLE` once no event is left and none is arriving. A rise event makes a pending, unmasked line in-service and raises the output that the line's vector selects. A fall event retires an in-service line and drops that output. An isolated input change shows on the outputs after three rising clock edges. A register write that creates events shows after the same three edges, counting the edge that takes the write.

Top module: `vec_intc`

## Requirements
- R1: For a line with its edge-select bit set, the pending bit is set only when the input is high and the line's last recorded level was low. The recorded level copies the input on every clock, so a line held high does not become pending again.
- R2: For a line with its edge-select bit clear, the pending bit copies the input level.
- R3: A rise event on a line that is pending and unmasked sets that line's in-service bit and drives parent output number vector[line] high. Queued events are served one per clock, lowest line first.
- R4: A fall event on a line that is in service clears its in-service bit and drives parent output number vector[line] low. An input going low produces a fall event.
- R5: A write to a mask half (low word 0x008, high word 0x00C; 1 = masked) produces a rise event for each bit that changes from 1 to 0. It produces a fall event for each bit that changes from 0 to 1.
- R6: Writing ones to the edge-clear register (0x020 low, 0x024 high) acts only on edge-mode lines. It clears their pending bit, clears their in-service bit and drops their vectored output. Level-mode lines are left untouched. The edge-select register is at 0x010 and 0x014.
- R7: Reading status (0x028 low, 0x02C high) returns in-service AND NOT mask. Writing status loads the in-service bits directly and does not change the parent outputs.
- R8: Each 64-bit register (mask, edge select, message enable 0x018/0x01C, polarity 0x030/0x034, status) is written one 32-bit half at a time. A write to one half leaves the other half unchanged.
- R9: Register 0x000 reads a fixed identification word. Register 0x004 reads the line count minus one in bits 31:16 and a fixed version (0x0001) in bits 15:0.
- R10: After reset, the mask is all ones. Edge select, message enable, polarity, pending, in-service, recorded levels and parent outputs are zero. Each vector entry is 0 and each route entry is 1.
- R11: Vector entry i sits at byte address 0x100+i and route entry i at 0x140+i, for i from 0 to 63. A write stores bits 7:0 of the write data. A read returns the byte zero-extended.
- R12: Reads of unmapped addresses return zero, and writes to them change no register.
- R13: Read data appears on `bus_rdata` in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NUM_LINES | Interrupt lines, already synchronous to clk |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| parent_irq | output | NUM_OUTS | Vectored parent interrupt outputs |

## Verification
The hardest situation to reach from the ports is an edge-mode line that is held high after its pending bit has been cleared. Pending state cannot be read directly. The stimulus therefore holds the input high, issues an edge clear, and then masks and unmasks the line. This forces a rise event that must find nothing pending. A second hard case is two lines rising in the same cycle. The bench samples the outputs one clock apart to see that the lower line is served first.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int MAX_LINES   = 64;
    localparam int TABLE_DEPTH = 64;
    localparam int DATA_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 9;
    localparam int IDX_W       = $clog2(MAX_LINES);
    localparam int TAB_IDX_W   = $clog2(TABLE_DEPTH);

    localparam logic [ADDR_W-1:0] A_ID_LO    = 9'h000;
    localparam logic [ADDR_W-1:0] A_ID_HI    = 9'h004;
    localparam logic [ADDR_W-1:0] A_MASK_LO  = 9'h008;
    localparam logic [ADDR_W-1:0] A_MASK_HI  = 9'h00C;
    localparam logic [ADDR_W-1:0] A_EDGE_LO  = 9'h010;
    localparam logic [ADDR_W-1:0] A_EDGE_HI  = 9'h014;
    localparam logic [ADDR_W-1:0] A_MSG_LO   = 9'h018;
    localparam logic [ADDR_W-1:0] A_MSG_HI   = 9'h01C;
    localparam logic [ADDR_W-1:0] A_CLR_LO   = 9'h020;
    localparam logic [ADDR_W-1:0] A_CLR_HI   = 9'h024;
    localparam logic [ADDR_W-1:0] A_STAT_LO  = 9'h028;
    localparam logic [ADDR_W-1:0] A_STAT_HI  = 9'h02C;
    localparam logic [ADDR_W-1:0] A_POL_LO   = 9'h030;
    localparam logic [ADDR_W-1:0] A_POL_HI   = 9'h034;
    localparam logic [ADDR_W-1:0] A_VEC_BASE = 9'h100;
    localparam logic [ADDR_W-1:0] A_RTE_BASE = 9'h140;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } vic_event_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } vic_state_e;
endpackage

// File: rtl/vic_line_tracker.sv
module vic_line_tracker
    import vic_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [MAX_LINES-1:0] edge_sel,
    input  logic [MAX_LINES-1:0] clr_hit,
    output logic [MAX_LINES-1:0] pend,
    output logic [MAX_LINES-1:0] rise,
    output logic [MAX_LINES-1:0] fall
);
    for (genvar g = 0; g < MAX_LINES; g++) begin : g_line
        if (g < NUM_LINES) begin : g_live
            logic lvl_q;
            logic pend_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q  <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    lvl_q <= irq_in[g];
                    if (clr_hit[g]) begin
                        pend_q <= 1'b0;
                    end else if (edge_sel[g]) begin
                        if (irq_in[g] && !lvl_q) begin
                            pend_q <= 1'b1;
                        end
                    end else begin
                        pend_q <= irq_in[g];
                    end
                end
            end

            assign pend[g] = pend_q;
            assign rise[g] = irq_in[g] & ~lvl_q;
            assign fall[g] = ~irq_in[g] & lvl_q;

            // R1: an edge line already seen high cannot become pending again
            a_r1_no_repeat_edge: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_sel[g] && lvl_q && !pend_q) |=> !pend_q);
        end else begin : g_tied
            assign pend[g] = 1'b0;
            assign rise[g] = 1'b0;
            assign fall[g] = 1'b0;
        end
    end
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int          NUM_LINES = 64,
    parameter logic [31:0] ID_WORD   = 32'h5649_4301,
    parameter logic [15:0] VERSION   = 16'h0001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [MAX_LINES-1:0] isr,
    output logic [MAX_LINES-1:0] mask,
    output logic [MAX_LINES-1:0] mask_rise,
    output logic [MAX_LINES-1:0] mask_fall,
    output logic [MAX_LINES-1:0] edge_sel,
    output logic [MAX_LINES-1:0] clr_hit,
    output logic [1:0]           isr_wr_en,
    output logic [DATA_W-1:0]    isr_wr_data,
    input  logic [IDX_W-1:0]     lk_idx,
    output logic [BYTE_W-1:0]    lk_vec
);
    localparam int          HALF       = DATA_W;
    localparam logic [15:0] LINES_M1   = 16'(NUM_LINES - 1);
    localparam int          TAB_TAG_W  = ADDR_W - TAB_IDX_W;

    logic [MAX_LINES-1:0] mask_q, edge_q, msg_q, pol_q;
    logic [BYTE_W-1:0]    vec_tab [TABLE_DEPTH];
    logic [BYTE_W-1:0]    rte_tab [TABLE_DEPTH];

    logic                 wr, rd;
    logic                 vec_hit, rte_hit;
    logic [TAB_IDX_W-1:0] tab_idx;
    logic [DATA_W-1:0]    rd_mux;

    assign wr      = bus_valid & bus_write;
    assign rd      = bus_valid & ~bus_write;
    assign tab_idx = bus_addr[TAB_IDX_W-1:0];
    assign vec_hit = bus_addr[ADDR_W-1:TAB_IDX_W] == A_VEC_BASE[ADDR_W-1:TAB_IDX_W];
    assign rte_hit = bus_addr[ADDR_W-1:TAB_IDX_W] == A_RTE_BASE[ADDR_W-1:TAB_IDX_W];

    function automatic logic [MAX_LINES-1:0] put_half(
        input logic [MAX_LINES-1:0] old_v,
        input logic                 upper,
        input logic [DATA_W-1:0]    val
    );
        logic [MAX_LINES-1:0] r;
        r = old_v;
        if (upper) r[MAX_LINES-1:HALF] = val;
        else       r[HALF-1:0]         = val;
        return r;
    endfunction

    // 64-bit control registers, written by halves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            edge_q <= '0;
            msg_q  <= '0;
            pol_q  <= '0;
        end else if (wr) begin
            unique case (bus_addr)
                A_MASK_LO: mask_q <= put_half(mask_q, 1'b0, bus_wdata);
                A_MASK_HI: mask_q <= put_half(mask_q, 1'b1, bus_wdata);
                A_EDGE_LO: edge_q <= put_half(edge_q, 1'b0, bus_wdata);
                A_EDGE_HI: edge_q <= put_half(edge_q, 1'b1, bus_wdata);
                A_MSG_LO:  msg_q  <= put_half(msg_q,  1'b0, bus_wdata);
                A_MSG_HI:  msg_q  <= put_half(msg_q,  1'b1, bus_wdata);
                A_POL_LO:  pol_q  <= put_half(pol_q,  1'b0, bus_wdata);
                A_POL_HI:  pol_q  <= put_half(pol_q,  1'b1, bus_wdata);
                default: ;
            endcase
        end
    end

    // byte tables
    for (genvar t = 0; t < TABLE_DEPTH; t++) begin : g_tab
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vec_tab[t] <= '0;
                rte_tab[t] <= BYTE_W'(1);
            end else if (wr && tab_idx == TAB_IDX_W'(t)) begin
                if (vec_hit) vec_tab[t] <= bus_wdata[BYTE_W-1:0];
                if (rte_hit) rte_tab[t] <= bus_wdata[BYTE_W-1:0];
            end
        end
    end

    // events derived from mask and clear writes
    always_comb begin
        mask_rise = '0;
        mask_fall = '0;
        clr_hit   = '0;
        if (wr) begin
            unique case (bus_addr)
                A_MASK_LO: begin
                    mask_rise[HALF-1:0] = mask_q[HALF-1:0] & ~bus_wdata;
                    mask_fall[HALF-1:0] = ~mask_q[HALF-1:0] & bus_wdata;
                end
                A_MASK_HI: begin
                    mask_rise[MAX_LINES-1:HALF] = mask_q[MAX_LINES-1:HALF] & ~bus_wdata;
                    mask_fall[MAX_LINES-1:HALF] = ~mask_q[MAX_LINES-1:HALF] & bus_wdata;
                end
                A_CLR_LO: clr_hit[HALF-1:0]           = bus_wdata & edge_q[HALF-1:0];
                A_CLR_HI: clr_hit[MAX_LINES-1:HALF]   = bus_wdata & edge_q[MAX_LINES-1:HALF];
                default: ;
            endcase
        end
    end

    assign isr_wr_en   = {wr && bus_addr == A_STAT_HI, wr && bus_addr == A_STAT_LO};
    assign isr_wr_data = bus_wdata;

    // read selection
    always_comb begin
        logic [MAX_LINES-1:0] vis;
        vis    = isr & ~mask_q;
        rd_mux = '0;
        if (vec_hit) begin
            rd_mux = DATA_W'(vec_tab[tab_idx]);
        end else if (rte_hit) begin
            rd_mux = DATA_W'(rte_tab[tab_idx]);
        end else begin
            unique case (bus_addr)
                A_ID_LO:   rd_mux = ID_WORD;
                A_ID_HI:   rd_mux = {LINES_M1, VERSION};
                A_MASK_LO: rd_mux = mask_q[HALF-1:0];
                A_MASK_HI: rd_mux = mask_q[MAX_LINES-1:HALF];
                A_EDGE_LO: rd_mux = edge_q[HALF-1:0];
                A_EDGE_HI: rd_mux = edge_q[MAX_LINES-1:HALF];
                A_MSG_LO:  rd_mux = msg_q[HALF-1:0];
                A_MSG_HI:  rd_mux = msg_q[MAX_LINES-1:HALF];
                A_STAT_LO: rd_mux = vis[HALF-1:0];
                A_STAT_HI: rd_mux = vis[MAX_LINES-1:HALF];
                A_POL_LO:  rd_mux = pol_q[HALF-1:0];
                A_POL_HI:  rd_mux = pol_q[MAX_LINES-1:HALF];
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
        else         bus_rdata <= '0;
    end

    assign mask     = mask_q;
    assign edge_sel = edge_q;
    assign lk_vec   = vec_tab[lk_idx];

    logic [TAB_TAG_W-1:0] unused_tag;
    assign unused_tag = '0;

    // R8: writing the low mask half keeps the high half
    a_r8_mask_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_MASK_LO) |=> mask_q[MAX_LINES-1:HALF] == $past(mask_q[MAX_LINES-1:HALF]));
    // R8: writing the high edge half keeps the low half
    a_r8_edge_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_EDGE_HI) |=> edge_q[HALF-1:0] == $past(edge_q[HALF-1:0]));
endmodule

// File: rtl/vic_dispatch.sv
module vic_dispatch
    import vic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_OUTS  = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_LINES-1:0] in_rise,
    input  logic [MAX_LINES-1:0] in_fall,
    input  logic [MAX_LINES-1:0] mask_rise,
    input  logic [MAX_LINES-1:0] mask_fall,
    input  logic [MAX_LINES-1:0] clr_hit,
    input  logic [MAX_LINES-1:0] pend,
    input  logic [MAX_LINES-1:0] mask,
    input  logic [1:0]           isr_wr_en,
    input  logic [DATA_W-1:0]    isr_wr_data,
    output logic [IDX_W-1:0]     sel_idx,
    input  logic [BYTE_W-1:0]    sel_vec,
    output logic [MAX_LINES-1:0] isr,
    output logic [NUM_OUTS-1:0]  parent_irq
);
    localparam int HALF = DATA_W;

    vic_state_e           state_q, state_d;
    vic_event_e           evt_q   [MAX_LINES];
    vic_event_e           new_evt [MAX_LINES];
    logic [MAX_LINES-1:0] has_evt, new_has, sel_hot;
    logic                 any_evt, more_evt, serve, vec_ok;
    logic [MAX_LINES-1:0] isr_q;
    logic [NUM_OUTS-1:0]  out_q;

    // newest event per line: clear first, then mask writes, then input changes
    always_comb begin
        for (int i = 0; i < MAX_LINES; i++) begin
            new_evt[i] = EV_NONE;
            if (i < NUM_LINES) begin
                if (clr_hit[i])        new_evt[i] = EV_FALL;
                else if (mask_rise[i]) new_evt[i] = EV_RISE;
                else if (mask_fall[i]) new_evt[i] = EV_FALL;
                else if (in_rise[i])   new_evt[i] = EV_RISE;
                else if (in_fall[i])   new_evt[i] = EV_FALL;
            end
            new_has[i] = new_evt[i] != EV_NONE;
            has_evt[i] = evt_q[i] != EV_NONE;
        end
    end

    // lowest queued line
    always_comb begin
        sel_idx = '0;
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (has_evt[i]) sel_idx = IDX_W'(i);
        end
    end

    assign any_evt  = |has_evt;
    assign sel_hot  = MAX_LINES'(1) << sel_idx;
    assign more_evt = (|(has_evt & ~sel_hot)) | (|new_has);
    assign serve    = (state_q == ST_SERVE) && any_evt;
    assign vec_ok   = int'(sel_vec) < NUM_OUTS;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_evt)   state_d = ST_SERVE;
            ST_SERVE: if (!more_evt) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // event queue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_LINES; i++) evt_q[i] <= EV_NONE;
        end else begin
            for (int i = 0; i < MAX_LINES; i++) begin
                if (new_has[i])                                 evt_q[i] <= new_evt[i];
                else if (serve && sel_idx == IDX_W'(i))         evt_q[i] <= EV_NONE;
            end
        end
    end

    // outputs: in-service bits and vectored parent lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
            out_q <= '0;
        end else begin
            if (serve) begin
                case (evt_q[sel_idx])
                    EV_RISE: if (pend[sel_idx] && !mask[sel_idx]) begin
                        isr_q[sel_idx] <= 1'b1;
                        if (vec_ok) out_q[sel_vec] <= 1'b1;
                    end
                    EV_FALL: if (isr_q[sel_idx]) begin
                        isr_q[sel_idx] <= 1'b0;
                        if (vec_ok) out_q[sel_vec] <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (isr_wr_en[0]) isr_q[HALF-1:0]           <= isr_wr_data;
            if (isr_wr_en[1]) isr_q[MAX_LINES-1:HALF]   <= isr_wr_data;
        end
    end

    assign isr        = isr_q;
    assign parent_irq = out_q;

    // R3: without a status write, at most one in-service bit moves per clock
    a_r3_one_line_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_wr_en == 2'b00) |=> $countones(isr_q ^ $past(isr_q)) <= 1);
    // R3: parent outputs move only while serving
    a_r3_idle_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(out_q));
    // R3: a masked line never enters service on a rise event
    a_r3_masked_no_service: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && evt_q[sel_idx] == EV_RISE && mask[sel_idx] && isr_wr_en == 2'b00)
        |=> isr_q == $past(isr_q));
    // R4: a served fall event leaves the line out of service
    a_r4_fall_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && evt_q[sel_idx] == EV_FALL && isr_wr_en == 2'b00)
        |=> !isr_q[$past(sel_idx)]);
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vic_pkg::*;
#(
    parameter int          NUM_LINES = 64,
    parameter int          NUM_OUTS  = 256,
    parameter logic [31:0] ID_WORD   = 32'h5649_4301,
    parameter logic [15:0] VERSION   = 16'h0001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [8:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_OUTS-1:0]  parent_irq
);
    logic [MAX_LINES-1:0] edge_sel, clr_hit, pend, in_rise, in_fall;
    logic [MAX_LINES-1:0] mask, mask_rise, mask_fall, isr;
    logic [1:0]           isr_wr_en;
    logic [DATA_W-1:0]    isr_wr_data;
    logic [IDX_W-1:0]     sel_idx;
    logic [BYTE_W-1:0]    sel_vec;

    vic_line_tracker #(.NUM_LINES(NUM_LINES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .edge_sel (edge_sel),
        .clr_hit  (clr_hit),
        .pend     (pend),
        .rise     (in_rise),
        .fall     (in_fall)
    );

    vic_regfile #(
        .NUM_LINES (NUM_LINES),
        .ID_WORD   (ID_WORD),
        .VERSION   (VERSION)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .isr         (isr),
        .mask        (mask),
        .mask_rise   (mask_rise),
        .mask_fall   (mask_fall),
        .edge_sel    (edge_sel),
        .clr_hit     (clr_hit),
        .isr_wr_en   (isr_wr_en),
        .isr_wr_data (isr_wr_data),
        .lk_idx      (sel_idx),
        .lk_vec      (sel_vec)
    );

    vic_dispatch #(
        .NUM_LINES (NUM_LINES),
        .NUM_OUTS  (NUM_OUTS)
    ) u_disp (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_rise     (in_rise),
        .in_fall     (in_fall),
        .mask_rise   (mask_rise),
        .mask_fall   (mask_fall),
        .clr_hit     (clr_hit),
        .pend        (pend),
        .mask        (mask),
        .isr_wr_en   (isr_wr_en),
        .isr_wr_data (isr_wr_data),
        .sel_idx     (sel_idx),
        .sel_vec     (sel_vec),
        .isr         (isr),
        .parent_irq  (parent_irq)
    );
endmodule

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
module vec_intc_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  irq = '0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] parent_irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mask_lo = 32'hFFFF_FFFF;

    always #2 clk = ~clk;

    vec_intc u_vec_intc (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .parent_irq (parent_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic set_mask_lo(input logic [31:0] v);
        mask_lo = v;
        bus_wr(9'h008, v);
        wait_n(4);
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        irq[n] = v;
        wait_n(4);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R10 parent idle", 32'($countones(parent_irq)), 32'd0);
        bus_rd(9'h008, d); check("R10 mask lo", d, 32'hFFFF_FFFF);
        bus_rd(9'h00C, d); check("R10 mask hi", d, 32'hFFFF_FFFF);
        bus_rd(9'h010, d); check("R10 edge lo", d, 32'h0);
        bus_rd(9'h030, d); check("R10 polarity lo", d, 32'h0);
        bus_rd(9'h147, d); check("R10 route 7", d, 32'h1);
        bus_rd(9'h107, d); check("R10 vector 7", d, 32'h0);
        bus_rd(9'h028, d); check("R10 status", d, 32'h0);
    endtask

    task automatic t_ident;
        logic [31:0] d;
        bus_rd(9'h004, d); check("R9 id hi", d, {16'd63, 16'h0001});
        bus_rd(9'h000, d); check("R9 id lo R13", d, 32'h5649_4301);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_wr(9'h03C, 32'hDEAD_BEEF);
        bus_rd(9'h03C, d); check("R12 unmapped read", d, 32'h0);
        bus_wr(9'h18C, 32'h1234_5678);
        bus_rd(9'h18C, d); check("R12 unmapped high", d, 32'h0);
        bus_rd(9'h008, d); check("R12 mask untouched", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_tables;
        logic [31:0] d;
        bus_wr(9'h103, 32'h0000_00A5);
        bus_wr(9'h143, 32'h0000_005A);
        bus_wr(9'h10A, 32'h1234_56C3);
        bus_rd(9'h103, d); check("R11 vector 3", d, 32'hA5);
        bus_rd(9'h143, d); check("R11 route 3", d, 32'h5A);
        bus_rd(9'h104, d); check("R11 vector 4 neighbour", d, 32'h0);
        bus_rd(9'h10A, d); check("R11 byte only", d, 32'hC3);
    endtask

    task automatic t_halves;
        logic [31:0] d;
        bus_wr(9'h00C, 32'h0000_FFFF);
        bus_rd(9'h008, d); check("R8 mask lo kept", d, 32'hFFFF_FFFF);
        bus_rd(9'h00C, d); check("R8 mask hi new", d, 32'h0000_FFFF);
        bus_wr(9'h01C, 32'hA5A5_0000);
        bus_rd(9'h018, d); check("R8 msg lo kept", d, 32'h0);
        bus_rd(9'h01C, d); check("R8 msg hi", d, 32'hA5A5_0000);
        bus_wr(9'h00C, 32'hFFFF_FFFF);
        wait_n(4);
        check("R8 no spurious output", 32'($countones(parent_irq)), 32'd0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        bus_wr(9'h102, 32'd9);
        set_mask_lo(mask_lo & ~32'h4);
        set_line(2, 1'b1);
        check("R2 R3 level raise", 32'(parent_irq[9]), 32'd1);
        bus_rd(9'h028, d); check("R7 status level", d, 32'h4);
        set_line(2, 1'b0);
        check("R4 level drop", 32'(parent_irq[9]), 32'd0);
        bus_rd(9'h028, d); check("R4 status cleared", d, 32'h0);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        bus_wr(9'h010, 32'h20);
        bus_wr(9'h105, 32'd20);
        set_mask_lo(mask_lo & ~32'h20);
        set_line(5, 1'b1);
        check("R1 edge raise", 32'(parent_irq[20]), 32'd1);
        bus_wr(9'h020, 32'h20);
        wait_n(4);
        check("R6 edge clear output", 32'(parent_irq[20]), 32'd0);
        bus_rd(9'h028, d); check("R6 edge clear status", d, 32'h0);
        set_mask_lo(mask_lo | 32'h20);
        set_mask_lo(mask_lo & ~32'h20);
        check("R1 held high not pending", 32'(parent_irq[20]), 32'd0);
        set_line(5, 1'b0);
        set_line(5, 1'b1);
        check("R1 new edge", 32'(parent_irq[20]), 32'd1);
        set_line(5, 1'b0);
        check("R4 edge line drop", 32'(parent_irq[20]), 32'd0);
    endtask

    task automatic t_clear_level_ignored;
        logic [31:0] d;
        set_line(2, 1'b1);
        bus_wr(9'h020, 32'h4);
        wait_n(4);
        check("R6 level line ignores clear", 32'(parent_irq[9]), 32'd1);
        bus_rd(9'h028, d); check("R6 level status kept", d, 32'h4);
        set_line(2, 1'b0);
    endtask

    task automatic t_mask_events;
        set_mask_lo(mask_lo | 32'h4);
        set_line(2, 1'b1);
        check("R5 masked no output", 32'(parent_irq[9]), 32'd0);
        set_mask_lo(mask_lo & ~32'h4);
        check("R5 unmask raises", 32'(parent_irq[9]), 32'd1);
        set_mask_lo(mask_lo | 32'h4);
        check("R5 mask drops", 32'(parent_irq[9]), 32'd0);
        set_line(2, 1'b0);
        set_mask_lo(mask_lo & ~32'h4);
    endtask

    task automatic t_priority;
        bus_wr(9'h107, 32'd30);
        bus_wr(9'h108, 32'd31);
        set_mask_lo(mask_lo & ~32'h180);
        @(negedge clk);
        irq[7] = 1'b1; irq[8] = 1'b1;
        wait_n(3);
        check("R3 lower line first", 32'(parent_irq[30]), 32'd1);
        check("R3 higher line waits", 32'(parent_irq[31]), 32'd0);
        wait_n(1);
        check("R3 higher line next", 32'(parent_irq[31]), 32'd1);
        @(negedge clk);
        irq[7] = 1'b0; irq[8] = 1'b0;
        wait_n(5);
        check("R4 both dropped", 32'($countones(parent_irq)), 32'd0);
    endtask

    task automatic t_status;
        logic [31:0] d;
        set_mask_lo(mask_lo & ~32'h1000);
        bus_wr(9'h028, 32'h1000);
        bus_rd(9'h028, d); check("R7 status load", d, 32'h1000);
        check("R7 outputs unchanged", 32'($countones(parent_irq)), 32'd0);
        bus_wr(9'h02C, 32'h1);
        bus_rd(9'h02C, d); check("R7 masked hidden", d, 32'h0);
        bus_wr(9'h028, 32'h0);
        bus_wr(9'h02C, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset;
        t_ident;
        t_unmapped;
        t_tables;
        t_halves;
        t_level;
        t_edge;
        t_clear_level_ignored;
        t_mask_events;
        t_priority;
        t_status;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule